// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor

This unit takes one 64-bit accumulator value and turns it into a 32-bit result in one of two ways. In shift mode it applies an arithmetic right shift by a 5-bit amount. Rounding to nearest is optional, and so is clamping the result to the 32-bit signed range. An overflow flag in the control word records when the accumulator cannot be represented in 32 bits, or when rounding pushes a positive accumulator past the top of the 64-bit range.

In position mode it reads a field of accumulator bits. The field's top bit comes from a 6-bit pointer held in the control word, and its width is set by the operand. The field is returned right-aligned. A flag marks the case where the field would run below bit 0. Optionally the pointer steps down past the field it has just read, so repeated reads walk through a bit stream.

Each request is presented for one cycle with `start`. One cycle later the unit presents the result and the updated control word, both registered. The caller writes the control word back. The accumulators themselves live elsewhere.

Top module: `xtr_field_extract`

## Requirements
- R1: While reset is asserted, and after it is released, `outValid`, `result` and `ctlOut` are all zero until the first request.
- R2: Each cycle with `start` high produces `outValid` high in the following cycle. No other cycle does. After a cycle with `start` low, `result` and `ctlOut` keep their values.
- R3: With `modeSel`=0 (shift mode) and neither rounding nor saturation, `result` is the low 32 bits of `accIn` arithmetically shifted right by `amt[4:0]`. An `amt` of 0 passes the low 32 bits of `accIn` unchanged.
- R4: With `roundEn`=1 and `amt`>0 in shift mode, 2^(`amt`-1) is added to `accIn` with 64-bit wrap before the shift.
- R5: If rounding turns a positive `accIn` negative, the overflow flag `ctlOut[23]` is set. With `satEn`=1, the value shifted is then the largest positive 64-bit number. Without it, the wrapped sum is shifted.
- R6: In shift mode, an `accIn` outside [-2^31, 2^31-1] sets `ctlOut[23]`. Without any overflow, `ctlOut[23]` equals `ctlIn[23]`, so the flag is only ever set and never cleared.
- R7: With `satEn`=1 in shift mode, the shifted value is clamped to 0x7FFFFFFF above and to 0x80000000 below.
- R8: With `modeSel`=1 (position mode), pos is `ctlIn[5:0]` and size is `amt[4:0]`. If pos >= size, `result` is `accIn` bits pos down to pos-size, zero-extended to 32 bits, and `ctlOut[14]` is 0.
- R9: In position mode with pos < size, `result` is 0, `ctlOut[14]` is 1 and `ctlOut[5:0]` equals pos.
- R10: In position mode with `decEn`=1 and a valid field, `ctlOut[5:0]` becomes pos-size-1. It becomes 63 when pos equals size. With `decEn`=0, `ctlOut[5:0]` equals pos.
- R11: Every `ctlOut` bit not named above copies `ctlIn`. Shift mode leaves bits 14 and 5:0 unchanged, and position mode leaves bit 23 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle per request |
| modeSel | input | 1 | 0 shift mode, 1 position mode |
| roundEn | input | 1 | Round before the shift (shift mode) |
| satEn | input | 1 | Clamp to the 32-bit signed range (shift mode) |
| decEn | input | 1 | Step the pointer down after a valid read (position mode) |
| accIn | input | 64 | Accumulator value |
| amt | input | 5 | Shift amount or field size minus one |
| ctlIn | input | 32 | Current control word |
| outValid | output | 1 | Result of the previous cycle's request is present |
| result | output | 32 | Extracted value |
| ctlOut | output | 32 | Updated control word |

## Verification
Every result and control-word update is due exactly one clock edge after the cycle in which `start` was high, and `outValid` marks that cycle. Between requests the outputs must stay put. A behavioural reference model in the bench updates its expected values on the same rising edge that the design registers them. All three outputs are compared against it on every falling edge, which keeps the sampling half a cycle away from the edge that changes the outputs. The directed cases cover the rounding-overflow, range-overflow, field-underflow and pointer-wrap corners before a stretch of mixed random requests with idle gaps.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
  typedef struct packed {
    logic load;
    logic posMode;
    logic rndEn;
    logic satEn;
    logic decEn;
    logic fieldOk;
  } xtrStrobes_t;
endpackage

// File: rtl/xtr_ctrl.sv
module xtr_ctrl
  import xtr_pkg::*;
#(
  parameter int AMT_W = 5,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeSel,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic             decEn,
  input  logic [POS_W-1:0] pos,
  input  logic [AMT_W-1:0] amt,
  output xtrStrobes_t      strobes,
  output logic             outValid
);
  localparam int CMP_W = ((POS_W > AMT_W) ? POS_W : AMT_W) + 1;

  logic [CMP_W-1:0] posWide;
  logic [CMP_W-1:0] sizeWide;

  assign posWide  = CMP_W'(pos);
  assign sizeWide = CMP_W'(amt);

  always_comb begin
    strobes.load    = start;
    strobes.posMode = modeSel;
    strobes.rndEn   = roundEn & ~modeSel;
    strobes.satEn   = satEn & ~modeSel;
    strobes.decEn   = decEn & modeSel;
    strobes.fieldOk = (posWide >= sizeWide);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= start;
  end
endmodule

// File: rtl/xtr_dp.sv
module xtr_dp
  import xtr_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int AMT_W   = 5,
  parameter int POS_W   = 6,
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 23,
  parameter int BAD_BIT = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  xtrStrobes_t      strobes,
  input  logic [ACC_W-1:0] accIn,
  input  logic [AMT_W-1:0] amt,
  input  logic [CTL_W-1:0] ctlIn,
  output logic [RES_W-1:0] result,
  output logic [CTL_W-1:0] ctlOut
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RES_MAX =
    {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RES_MIN = ~RES_MAX;
  localparam int TOP_W = ACC_W - RES_W + 1;

  logic [ACC_W-1:0]        rndAdd;
  logic [ACC_W-1:0]        sum;
  logic [ACC_W-1:0]        pre;
  logic signed [ACC_W-1:0] shifted;
  logic                    rndOvf;
  logic                    rangeOvf;
  logic [TOP_W-1:0]        topBits;
  logic [RES_W-1:0]        shiftRes;

  logic [POS_W-1:0]        pos;
  logic [POS_W-1:0]        lowBit;
  logic [POS_W-1:0]        nextPos;
  logic [RES_W:0]          maskW;
  logic [RES_W-1:0]        fieldRes;

  logic [RES_W-1:0]        resNext;
  logic [CTL_W-1:0]        ctlNext;

  // shift path
  always_comb begin
    rndAdd   = (amt == '0) ? '0 : (ACC_W'(1) << (amt - 1'b1));
    sum      = accIn + rndAdd;
    rndOvf   = strobes.rndEn && (amt != '0) && !accIn[ACC_W-1] &&
               (accIn != '0) && sum[ACC_W-1];
    pre      = strobes.rndEn ? sum : accIn;
    if (rndOvf && strobes.satEn) pre = ACC_MAX;
    shifted  = $signed(pre) >>> amt;
    topBits  = accIn[ACC_W-1:RES_W-1];
    rangeOvf = !((&topBits) || (~|topBits));
    if (strobes.satEn && (shifted > RES_MAX))      shiftRes = RES_MAX[RES_W-1:0];
    else if (strobes.satEn && (shifted < RES_MIN)) shiftRes = RES_MIN[RES_W-1:0];
    else                                           shiftRes = shifted[RES_W-1:0];
  end

  // position path
  always_comb begin
    pos      = ctlIn[POS_W-1:0];
    lowBit   = pos - POS_W'(amt);
    nextPos  = lowBit - 1'b1;
    maskW    = ((RES_W+1)'(1) << ({1'b0, amt} + 1'b1)) - 1'b1;
    fieldRes = RES_W'(accIn >> lowBit) & maskW[RES_W-1:0];
  end

  // merge
  always_comb begin
    ctlNext = ctlIn;
    if (strobes.posMode) begin
      resNext          = strobes.fieldOk ? fieldRes : '0;
      ctlNext[BAD_BIT] = ~strobes.fieldOk;
      if (strobes.fieldOk && strobes.decEn) ctlNext[POS_W-1:0] = nextPos;
    end else begin
      resNext = shiftRes;
      if (rndOvf || rangeOvf) ctlNext[OVF_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      ctlOut <= '0;
    end else if (strobes.load) begin
      result <= resNext;
      ctlOut <= ctlNext;
    end
  end
endmodule

// File: rtl/xtr_field_extract.sv
module xtr_field_extract
  import xtr_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int AMT_W   = 5,
  parameter int POS_W   = 6,
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 23,
  parameter int BAD_BIT = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeSel,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic             decEn,
  input  logic [ACC_W-1:0] accIn,
  input  logic [AMT_W-1:0] amt,
  input  logic [CTL_W-1:0] ctlIn,
  output logic             outValid,
  output logic [RES_W-1:0] result,
  output logic [CTL_W-1:0] ctlOut
);
  xtrStrobes_t strobes;

  xtr_ctrl #(.AMT_W(AMT_W), .POS_W(POS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .roundEn(roundEn), .satEn(satEn), .decEn(decEn),
    .pos(ctlIn[POS_W-1:0]), .amt(amt),
    .strobes(strobes), .outValid(outValid)
  );

  xtr_dp #(
    .ACC_W(ACC_W), .RES_W(RES_W), .AMT_W(AMT_W), .POS_W(POS_W),
    .CTL_W(CTL_W), .OVF_BIT(OVF_BIT), .BAD_BIT(BAD_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accIn(accIn),
    .amt(amt), .ctlIn(ctlIn), .result(result), .ctlOut(ctlOut)
  );
endmodule

// File: rtl/xtr_field_extract_chk.sv
module xtr_field_extract_chk #(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int AMT_W   = 5,
  parameter int POS_W   = 6,
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 23,
  parameter int BAD_BIT = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             modeSel,
  input logic             decEn,
  input logic [ACC_W-1:0] accIn,
  input logic [AMT_W-1:0] amt,
  input logic [CTL_W-1:0] ctlIn,
  input logic             outValid,
  input logic [RES_W-1:0] result,
  input logic [CTL_W-1:0] ctlOut
);
  logic outOfRange;
  assign outOfRange = !((&accIn[ACC_W-1:RES_W-1]) || (~|accIn[ACC_W-1:RES_W-1]));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> outValid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!outValid && $stable(result) && $stable(ctlOut)));
  // R6
  range_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !modeSel && outOfRange) |=> ctlOut[OVF_BIT]);
  // R9
  bad_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && modeSel && (ctlIn[POS_W-1:0] < POS_W'(amt))) |=> (result == '0 && ctlOut[BAD_BIT]));
  // R10
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && modeSel && decEn && (ctlIn[POS_W-1:0] == POS_W'(amt))) |=> (&ctlOut[POS_W-1:0]));
  // R11
  pos_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && modeSel) |=> (ctlOut[OVF_BIT] == $past(ctlIn[OVF_BIT])));
endmodule

bind xtr_field_extract xtr_field_extract_chk #(
  .ACC_W(ACC_W), .RES_W(RES_W), .AMT_W(AMT_W), .POS_W(POS_W),
  .CTL_W(CTL_W), .OVF_BIT(OVF_BIT), .BAD_BIT(BAD_BIT)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel), .decEn(decEn),
  .accIn(accIn), .amt(amt), .ctlIn(ctlIn), .outValid(outValid),
  .result(result), .ctlOut(ctlOut)
);

// File: tb/tb_xtr_field_extract.sv
module tb_xtr_field_extract;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, modeSel = 1'b0, roundEn = 1'b0, satEn = 1'b0, decEn = 1'b0;
  logic [63:0] accIn = '0;
  logic [4:0]  amt = '0;
  logic [31:0] ctlIn = '0;
  logic        outValid;
  logic [31:0] result, ctlOut;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        expValid = 0;
  logic [31:0] expRes = '0, expCtl = '0;
  string       expTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  xtr_field_extract dut (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .roundEn(roundEn), .satEn(satEn), .decEn(decEn), .accIn(accIn),
    .amt(amt), .ctlIn(ctlIn), .outValid(outValid), .result(result), .ctlOut(ctlOut)
  );

  // reference model, updated on the same edge the design registers
  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0; expRes = '0; expCtl = '0; expTag = "R1";
    end else begin
      expValid = start;
      if (!start) expTag = "R2";
      else if (modeSel) begin : posModel
        int p, s, np;
        logic [63:0] m;
        p = int'(ctlIn[5:0]); s = int'(amt);
        expCtl = ctlIn;
        if (p >= s) begin
          m = (64'd1 << (s + 1)) - 64'd1;
          expRes = 32'((accIn >> (p - s)) & m);
          expCtl[14] = 1'b0;
          expTag = "R8";
          if (decEn) begin
            np = p - s - 1;
            if (np == -1) np = 63;
            expCtl[5:0] = 6'(np);
            expTag = "R10";
          end
        end else begin
          expRes = '0; expCtl[14] = 1'b1; expTag = "R9";
        end
      end else begin : shiftModel
        longint a, t;
        bit ovf, rovf;
        int sa;
        a = longint'(accIn); sa = int'(amt); ovf = 0; rovf = 0;
        if (sa > 0) begin
          if (roundEn) begin
            t = a + (longint'(1) << (sa - 1));
            if (a > 0 && t < 0) begin
              rovf = 1;
              if (satEn) t = 64'sh7FFF_FFFF_FFFF_FFFF;
            end
            t = t >>> sa;
          end else t = a >>> sa;
        end else t = a;
        if (a > 64'sd2147483647 || a < -64'sd2147483648) ovf = 1;
        if (satEn && t > 64'sd2147483647)       expRes = 32'h7FFF_FFFF;
        else if (satEn && t < -64'sd2147483648) expRes = 32'h8000_0000;
        else                                   expRes = 32'(t);
        expCtl = ctlIn;
        if (ovf || rovf) expCtl[23] = 1'b1;
        if (rovf) expTag = "R5";
        else if (ovf && satEn) expTag = "R7";
        else if (ovf) expTag = "R6";
        else if (roundEn) expTag = "R4";
        else expTag = "R3";
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (outValid !== expValid) begin
        fails++; $display("FAIL %s outValid got %0b exp %0b", (expTag == "R1") ? "R1" : "R2", outValid, expValid);
      end
      checks++;
      if (result !== expRes) begin
        fails++; $display("FAIL %s result got %h exp %h", expTag, result, expRes);
      end
      checks++;
      if (ctlOut !== expCtl) begin
        fails++; $display("FAIL %s/R11 ctlOut got %h exp %h", expTag, ctlOut, expCtl);
      end
    end
  end

  task automatic op(input bit m, input bit r, input bit s, input bit d,
                    input logic [63:0] a, input logic [4:0] n, input logic [31:0] c);
    @(posedge clk); #1;
    start = 1; modeSel = m; roundEn = r; satEn = s; decEn = d;
    accIn = a; amt = n; ctlIn = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      start = 0; accIn = {$urandom, $urandom}; ctlIn = $urandom; amt = 5'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset phase
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    idle(2);
    // R3 plain shift
    op(0,0,0,0, 64'h0000_0000_1234_5678, 5'd0, 32'h0);
    op(0,0,0,0, 64'hFFFF_FFFF_FFFF_0000, 5'd8, 32'h0);
    // R4 rounding
    op(0,1,0,0, 64'h0000_0000_0000_0180, 5'd8, 32'h0);
    op(0,1,0,0, 64'hFFFF_FFFF_FFFF_FF7F, 5'd8, 32'h0);
    // R5 rounding overflow with and without saturation
    op(0,1,1,0, 64'h7FFF_FFFF_FFFF_FFFF, 5'd1, 32'h0);
    op(0,1,0,0, 64'h7FFF_FFFF_FFFF_FFFF, 5'd1, 32'h0);
    // R6 range overflow, flag sticky and passthrough
    op(0,0,0,0, 64'h0000_0100_0000_0000, 5'd4, 32'h0);
    op(0,0,0,0, 64'h0000_0000_0000_0010, 5'd4, 32'h0080_0000);
    // R7 saturation both ends
    op(0,0,1,0, 64'h0000_0100_0000_0000, 5'd2, 32'h0);
    op(0,0,1,0, 64'hFFFF_FF00_0000_0000, 5'd2, 32'h0);
    // R8 field reads
    op(1,0,0,0, 64'h0000_AB00_0000_0000, 5'd7, 32'h0000_002F);
    op(1,0,0,0, 64'hDEAD_BEEF_CAFE_F00D, 5'd31, 32'h0000_001F);
    // R9 underflow
    op(1,0,0,1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd5, 32'h0000_0003);
    // R10 decrement and wrap
    op(1,0,0,1, 64'h0000_0000_0000_1F00, 5'd4, 32'h0000_000C);
    op(1,0,0,1, 64'h0000_0000_0000_0003, 5'd4, 32'h0000_0004);
    // R11 unrelated bits preserved
    op(1,0,0,1, 64'h1234_5678_9ABC_DEF0, 5'd3, 32'hA5A5_C03F);
    op(0,1,1,0, 64'h1234_5678_9ABC_DEF0, 5'd3, 32'h5A5A_7FC0);
    // R2 hold while idle
    idle(4);
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if (k % 3 == 0) a = {{32{a[31]}}, a[31:0]};
      op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), a, 5'($urandom), $urandom);
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(3);
    @(negedge clk); #1;
    finish_run();
  end
endmodule